// File: doc/BRIEF.md
# Bridge Configuration Register Controller

This block holds the configuration registers that a PCI-to-PCI bridge carries in its type-1 header. It stores three bus numbers, the secondary latency timer, and the base and limit fields of three forwarding windows: I/O, memory and prefetchable memory. It also holds the upper halves of the I/O and prefetchable windows, the bridge control word and the command word. Accesses are single configuration requests. Each request names a dword index and carries four byte enables, and a read answers one cycle later. The status words and the header type are constants, and writes to them have no effect.

Some writes also update the windows that a separate decoder applies. Such a write raises a one-cycle remap pulse once the new value is in the registers. When software turns the secondary-bus reset control on, the block drives a secondary reset output for a fixed number of cycles. A separate forwarding-disable input loads a preset that closes all three windows, because every base then lies above its limit. Reset loads another preset that zeroes the address fields.

Top module: `bridge_cfg_regs`

## Requirements
- R1: After reset, dwords 0x18 (bus numbers and latency timer), 0x30 (I/O upper halves) and 0x3C (bridge control in bits 31:16) read zero, and the command word (dword 0x04, bits 15:0) reads zero.
- R2: After reset the address bits of every base and limit field are zero, and both prefetchable upper dwords (0x28, 0x2C) read zero. The type nibbles stay as they are: 0x1 in bits 3:0 and 11:8 of dword 0x1C when IO_32BIT=1, and 0x1 in bits 3:0 and 19:16 of dword 0x24 when PREF_64BIT=1.
- R3: A one-cycle pulse on fwd_disable does four things: it sets the I/O base nibble (0x1C bits 7:4) and both 12-bit memory base fields (bits 15:4 of 0x20 and 0x24) to all ones, it clears the matching limit fields, it clears dwords 0x28 and 0x2C, and it raises remap_pulse in the next cycle.
- R4: remap_pulse is high for exactly the one cycle after a write whose enabled bytes touch byte addresses 0x04-0x05, 0x1C-0x1D, 0x20-0x33 or 0x3E-0x3F. A write that touches none of these bytes leaves it low.
- R5: A write to dword 0x3C with byte enable 2 set that turns bit 22 (secondary-bus reset control) from 0 to 1 drives sec_bus_reset high for RST_HOLD cycles, starting in the cycle after the write.
- R6: Writing bit 22 while it is already 1, clearing it, or leaving it untouched through a disabled byte produces no sec_bus_reset pulse.
- R7: Bits 31:16 of dwords 0x04 and 0x1C read the fixed status value 0x00A0 (66 MHz capable and fast back-to-back capable).
- R8: Byte 0x0E (dword 0x0C, bits 23:16) reads {MULTI_FUNC, 7'h01}, and every other bit of that dword reads zero.
- R9: A read raises cfg_rvalid in the next cycle, with cfg_rdata holding the contents as they were before the request edge. An index with no register reads zero.
- R10: Writes to the status bits, the header type, the type nibbles and the low nibble of the memory base and limit dwords are ignored.
- R11: A write changes only the bytes whose enable bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_req | input | 1 | Configuration request strobe, one cycle per access |
| cfg_we | input | 1 | 1 = write, 0 = read |
| cfg_idx | input | 6 | Dword index into the 256-byte configuration space |
| cfg_be | input | 4 | Byte enables, bit n selects byte n of the dword |
| cfg_wdata | input | 32 | Write data |
| fwd_disable | input | 1 | Loads the window-closing preset |
| cfg_rvalid | output | 1 | Read data valid, one cycle after a read request |
| cfg_rdata | output | 32 | Read data |
| remap_pulse | output | 1 | One-cycle pulse telling the window decoder to reload its bounds |
| sec_bus_reset | output | 1 | Secondary bus reset, high for RST_HOLD cycles |

## Verification
The bench builds the block with RST_HOLD=3 and MULTI_FUNC=1, keeping IO_32BIT and PREF_64BIT at 1. A hold of three cycles makes the length of the reset pulse and its retrigger quick to observe. The multi-function setting makes the preserved bit show in the header byte, and the two type settings make the upper-half registers writable and the type nibbles non-zero. The bench writes into each remap range and just past its edges, and it sets the secondary-reset bit from 0, from 1 and through a disabled byte.

// File: rtl/bcr_pkg.sv
package bcr_pkg;
    localparam int CFG_IDX_W = 6;
    typedef logic [CFG_IDX_W-1:0] dw_idx_t;

    localparam dw_idx_t IDX_CMD  = 6'd1;
    localparam dw_idx_t IDX_HDR  = 6'd3;
    localparam dw_idx_t IDX_BUS  = 6'd6;
    localparam dw_idx_t IDX_IO   = 6'd7;
    localparam dw_idx_t IDX_MEM  = 6'd8;
    localparam dw_idx_t IDX_PF   = 6'd9;
    localparam dw_idx_t IDX_PFBH = 6'd10;
    localparam dw_idx_t IDX_PFLH = 6'd11;
    localparam dw_idx_t IDX_IOH  = 6'd12;
    localparam dw_idx_t IDX_CTL  = 6'd15;

    localparam logic [15:0] STAT_FIXED = 16'h00A0;
    localparam int SBR_BIT = 6;

    typedef struct packed {
        logic [15:0] cmd;
        logic [7:0]  pri_bus;
        logic [7:0]  sec_bus;
        logic [7:0]  sub_bus;
        logic [7:0]  sec_lat;
        logic [3:0]  io_base;
        logic [3:0]  io_lim;
        logic [11:0] mem_base;
        logic [11:0] mem_lim;
        logic [11:0] pf_base;
        logic [11:0] pf_lim;
        logic [31:0] pf_base_hi;
        logic [31:0] pf_lim_hi;
        logic [15:0] io_base_hi;
        logic [15:0] io_lim_hi;
        logic [15:0] brctl;
    } bcr_regs_t;

    function automatic logic [31:0] lane_merge(logic [31:0] old, logic [31:0] nw,
                                               logic [3:0] be);
        logic [31:0] r;
        for (int b = 0; b < 4; b++)
            r[b*8 +: 8] = be[b] ? nw[b*8 +: 8] : old[b*8 +: 8];
        return r;
    endfunction

    function automatic logic remap_hit(dw_idx_t idx, logic [3:0] be);
        logic h;
        case (idx)
            IDX_CMD, IDX_IO: h = be[0] | be[1];
            IDX_MEM, IDX_PF, IDX_PFBH, IDX_PFLH, IDX_IOH: h = |be;
            IDX_CTL: h = be[2] | be[3];
            default: h = 1'b0;
        endcase
        return h;
    endfunction
endpackage

// File: rtl/bcr_regfile.sv
module bcr_regfile
    import bcr_pkg::*;
#(
    parameter int IO_32BIT   = 1,
    parameter int PREF_64BIT = 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  dw_idx_t         idx,
    input  logic [3:0]      be,
    input  logic [31:0]     wdata,
    input  logic            dis_fwd,
    output bcr_regs_t       regs
);
    bcr_regs_t nxt;

    always_comb begin
        nxt = regs;
        if (wr_en) begin
            case (idx)
                IDX_CMD: begin
                    if (be[0]) nxt.cmd[7:0]  = wdata[7:0];
                    if (be[1]) nxt.cmd[15:8] = wdata[15:8];
                end
                IDX_BUS:
                    {nxt.sec_lat, nxt.sub_bus, nxt.sec_bus, nxt.pri_bus} =
                        lane_merge({regs.sec_lat, regs.sub_bus, regs.sec_bus, regs.pri_bus},
                                   wdata, be);
                IDX_IO: begin
                    if (be[0]) nxt.io_base = wdata[7:4];
                    if (be[1]) nxt.io_lim  = wdata[15:12];
                end
                IDX_MEM: begin
                    if (be[0]) nxt.mem_base[3:0]  = wdata[7:4];
                    if (be[1]) nxt.mem_base[11:4] = wdata[15:8];
                    if (be[2]) nxt.mem_lim[3:0]   = wdata[23:20];
                    if (be[3]) nxt.mem_lim[11:4]  = wdata[31:24];
                end
                IDX_PF: begin
                    if (be[0]) nxt.pf_base[3:0]  = wdata[7:4];
                    if (be[1]) nxt.pf_base[11:4] = wdata[15:8];
                    if (be[2]) nxt.pf_lim[3:0]   = wdata[23:20];
                    if (be[3]) nxt.pf_lim[11:4]  = wdata[31:24];
                end
                IDX_PFBH: if (PREF_64BIT != 0) nxt.pf_base_hi = lane_merge(regs.pf_base_hi, wdata, be);
                IDX_PFLH: if (PREF_64BIT != 0) nxt.pf_lim_hi  = lane_merge(regs.pf_lim_hi, wdata, be);
                IDX_IOH:
                    if (IO_32BIT != 0)
                        {nxt.io_lim_hi, nxt.io_base_hi} =
                            lane_merge({regs.io_lim_hi, regs.io_base_hi}, wdata, be);
                IDX_CTL: begin
                    if (be[2]) nxt.brctl[7:0]  = wdata[23:16];
                    if (be[3]) nxt.brctl[15:8] = wdata[31:24];
                end
                default: ;
            endcase
        end
        if (dis_fwd) begin
            nxt.io_base    = '1;
            nxt.io_lim     = '0;
            nxt.mem_base   = '1;
            nxt.mem_lim    = '0;
            nxt.pf_base    = '1;
            nxt.pf_lim     = '0;
            nxt.pf_base_hi = '0;
            nxt.pf_lim_hi  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) regs <= '0;
        else     regs <= nxt;
    end

    // R3
    fwd_close_chk: assert property (@(posedge clk) disable iff (rst)
        dis_fwd |=> (regs.io_base == 4'hF && regs.io_lim == 4'h0 &&
                     regs.mem_base == 12'hFFF && regs.mem_lim == 12'h000 &&
                     regs.pf_base_hi == 32'h0 && regs.pf_lim_hi == 32'h0));
endmodule

// File: rtl/bcr_events.sv
module bcr_events
    import bcr_pkg::*;
#(
    parameter int RST_HOLD = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  dw_idx_t     idx,
    input  logic [3:0]  be,
    input  logic        sbr_new,
    input  logic        sbr_cur,
    input  logic        dis_fwd,
    output logic        remap_pulse,
    output logic        sec_reset
);
    localparam int CNT_W = $clog2(RST_HOLD + 1);

    logic [CNT_W-1:0] hold_cnt;
    logic             sbr_rise;

    assign sbr_rise  = wr_en && (idx == IDX_CTL) && be[2] && sbr_new && !sbr_cur;
    assign sec_reset = (hold_cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_cnt    <= '0;
            remap_pulse <= 1'b0;
        end else begin
            remap_pulse <= (wr_en && remap_hit(idx, be)) || dis_fwd;
            if (sbr_rise)
                hold_cnt <= CNT_W'(RST_HOLD);
            else if (hold_cnt != '0)
                hold_cnt <= hold_cnt - 1'b1;
        end
    end

    // R4
    remap_cause_chk: assert property (@(posedge clk) disable iff (rst)
        remap_pulse |-> $past(wr_en || dis_fwd));
    // R5
    sbr_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sec_reset) |-> $past(wr_en && idx == IDX_CTL && be[2] && sbr_new));
    // R6
    sbr_edge_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sec_reset) |-> !$past(sbr_cur));

    generate
        if (RST_HOLD > 1) begin : g_hold
            // R5
            sbr_hold_chk: assert property (@(posedge clk) disable iff (rst)
                $rose(sec_reset) |=> sec_reset);
        end
    endgenerate
endmodule

// File: rtl/bcr_readmux.sv
module bcr_readmux
    import bcr_pkg::*;
#(
    parameter int MULTI_FUNC = 0,
    parameter int IO_32BIT   = 1,
    parameter int PREF_64BIT = 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rd_en,
    input  dw_idx_t     idx,
    input  bcr_regs_t   regs,
    output logic        rvalid,
    output logic [31:0] rdata
);
    localparam logic       MF_BIT = (MULTI_FUNC != 0);
    localparam logic [3:0] IO_T   = (IO_32BIT != 0)   ? 4'h1 : 4'h0;
    localparam logic [3:0] PF_T   = (PREF_64BIT != 0) ? 4'h1 : 4'h0;

    logic [31:0] view;

    always_comb begin
        case (idx)
            IDX_CMD:  view = {STAT_FIXED, regs.cmd};
            IDX_HDR:  view = {8'h00, MF_BIT, 7'h01, 16'h0000};
            IDX_BUS:  view = {regs.sec_lat, regs.sub_bus, regs.sec_bus, regs.pri_bus};
            IDX_IO:   view = {STAT_FIXED, regs.io_lim, IO_T, regs.io_base, IO_T};
            IDX_MEM:  view = {regs.mem_lim, 4'h0, regs.mem_base, 4'h0};
            IDX_PF:   view = {regs.pf_lim, PF_T, regs.pf_base, PF_T};
            IDX_PFBH: view = regs.pf_base_hi;
            IDX_PFLH: view = regs.pf_lim_hi;
            IDX_IOH:  view = {regs.io_lim_hi, regs.io_base_hi};
            IDX_CTL:  view = {regs.brctl, 16'h0000};
            default:  view = 32'h0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= rd_en;
            if (rd_en) rdata <= view;
        end
    end

    // R9
    read_ack_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rvalid);
    // R9
    read_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rvalid);
endmodule

// File: rtl/bridge_cfg_regs.sv
module bridge_cfg_regs
    import bcr_pkg::*;
#(
    parameter int RST_HOLD   = 4,
    parameter int MULTI_FUNC = 0,
    parameter int IO_32BIT   = 1,
    parameter int PREF_64BIT = 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_req,
    input  logic                 cfg_we,
    input  logic [CFG_IDX_W-1:0] cfg_idx,
    input  logic [3:0]           cfg_be,
    input  logic [31:0]          cfg_wdata,
    input  logic                 fwd_disable,
    output logic                 cfg_rvalid,
    output logic [31:0]          cfg_rdata,
    output logic                 remap_pulse,
    output logic                 sec_bus_reset
);
    logic      wr_en;
    logic      rd_en;
    bcr_regs_t regs;

    assign wr_en = cfg_req && cfg_we;
    assign rd_en = cfg_req && !cfg_we;

    bcr_regfile #(.IO_32BIT(IO_32BIT), .PREF_64BIT(PREF_64BIT)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .idx(cfg_idx), .be(cfg_be),
        .wdata(cfg_wdata), .dis_fwd(fwd_disable), .regs(regs)
    );

    bcr_events #(.RST_HOLD(RST_HOLD)) u_events (
        .clk(clk), .rst(rst), .wr_en(wr_en), .idx(cfg_idx), .be(cfg_be),
        .sbr_new(cfg_wdata[16+SBR_BIT]), .sbr_cur(regs.brctl[SBR_BIT]),
        .dis_fwd(fwd_disable), .remap_pulse(remap_pulse), .sec_reset(sec_bus_reset)
    );

    bcr_readmux #(.MULTI_FUNC(MULTI_FUNC), .IO_32BIT(IO_32BIT), .PREF_64BIT(PREF_64BIT)) u_rd (
        .clk(clk), .rst(rst), .rd_en(rd_en), .idx(cfg_idx), .regs(regs),
        .rvalid(cfg_rvalid), .rdata(cfg_rdata)
    );
endmodule

// File: tb/bridge_cfg_regs_bench.sv
module bridge_cfg_regs_bench;
    localparam int HOLD = 3;
    localparam int MF   = 1;

    logic clk = 1'b0, rst = 1'b1, req = 1'b0, we = 1'b0, dis = 1'b0;
    logic [5:0]  idx = '0;
    logic [3:0]  be = '0;
    logic [31:0] wd = '0;
    logic        rvalid, remap_pulse, sec_bus_reset;
    logic [31:0] rdata;

    int errors = 0, checks = 0;
    bit done = 0, started = 0;

    logic [31:0] m [16];
    int          scnt = 0;
    bit          e_remap = 0, e_rv = 0;
    logic [31:0] e_rd = '0;

    always #10 clk = ~clk;

    bridge_cfg_regs #(.RST_HOLD(HOLD), .MULTI_FUNC(MF)) u_bridge_cfg_regs (
        .clk(clk), .rst(rst), .cfg_req(req), .cfg_we(we), .cfg_idx(idx), .cfg_be(be),
        .cfg_wdata(wd), .fwd_disable(dis), .cfg_rvalid(rvalid), .cfg_rdata(rdata),
        .remap_pulse(remap_pulse), .sec_bus_reset(sec_bus_reset)
    );

    function automatic logic [31:0] wmask(int i);
        case (i)
            1: return 32'h0000FFFF;
            6, 10, 11, 12: return 32'hFFFFFFFF;
            7: return 32'h0000F0F0;
            8, 9: return 32'hFFF0FFF0;
            15: return 32'hFFFF0000;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] romask(int i);
        case (i)
            1: return 32'h00A00000;
            3: return {8'h00, 1'(MF), 7'h01, 16'h0000};
            7: return 32'h00A00101;
            9: return 32'h00010001;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] model_rd(int i);
        if (i < 16) return m[i] | romask(i);
        return 32'h0;
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // reference model, updated at each rising edge
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 16; i++) m[i] = 32'h0;
            scnt = 0; e_remap = 0; e_rv = 0;
        end else begin
            bit hit, rise;
            logic [31:0] bm;
            hit = 0; rise = 0;
            e_rv = req && !we;
            e_rd = model_rd(int'(idx));
            if (req && we) begin
                for (int b = 0; b < 4; b++) begin
                    int a;
                    a = int'(idx) * 4 + b;
                    if (be[b] && ((a >= 4 && a <= 5) || (a >= 28 && a <= 29) ||
                                  (a >= 32 && a <= 51) || (a >= 62 && a <= 63)))
                        hit = 1;
                end
                if (idx == 6'd15 && be[2] && wd[22] && !m[15][22]) rise = 1;
                if (idx < 6'd16) begin
                    bm = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}} & wmask(int'(idx));
                    m[idx[3:0]] = (m[idx[3:0]] & ~bm) | (wd & bm);
                end
            end
            if (dis) begin
                m[7]  = (m[7] | 32'h000000F0) & ~32'h0000F000;
                m[8]  = 32'h0000FFF0;
                m[9]  = 32'h0000FFF0;
                m[10] = 32'h0;
                m[11] = 32'h0;
            end
            if (rise) scnt = HOLD;
            else if (scnt > 0) scnt--;
            e_remap = (req && we && hit) || dis;
        end
        started = 1;
    end

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (started && !done) begin
            chk(remap_pulse === e_remap, "R4 remap_pulse vs model", 32'(remap_pulse), 32'(e_remap));
            chk(sec_bus_reset === (scnt > 0), "R5 sec_bus_reset vs model", 32'(sec_bus_reset), 32'(scnt > 0));
            chk(rvalid === e_rv, "R9 cfg_rvalid vs model", 32'(rvalid), 32'(e_rv));
            if (e_rv) chk(rdata === e_rd, "R9 cfg_rdata vs model", rdata, e_rd);
        end
    end

    task automatic wr(input logic [5:0] i, input logic [3:0] b, input logic [31:0] d,
                      output bit r, output bit s);
        @(negedge clk);
        req = 1; we = 1; idx = i; be = b; wd = d;
        @(negedge clk);
        r = remap_pulse; s = sec_bus_reset;
        req = 0; we = 0; be = '0;
    endtask

    task automatic rd_chk(input logic [5:0] i, input logic [31:0] exp, input string tag);
        @(negedge clk);
        req = 1; we = 0; idx = i;
        @(negedge clk);
        chk(rvalid === 1'b1, tag, 32'(rvalid), 32'h1);
        chk(rdata === exp, tag, rdata, exp);
        req = 0;
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #(20 * 50000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL R9 watchdog expired got=0 exp=1");
            summary();
            $finish;
        end
    end

    initial begin
        bit r, s;
        int hi;
        repeat (3) @(negedge clk);
        rst = 0;
        // reset presets
        rd_chk(6'd6,  32'h00000000, "R1 bus numbers after reset");
        rd_chk(6'd15, 32'h00000000, "R1 bridge control after reset");
        rd_chk(6'd12, 32'h00000000, "R1 io upper after reset");
        rd_chk(6'd1,  32'h00A00000, "R7 R1 command/status after reset");
        rd_chk(6'd7,  32'h00A00101, "R2 R7 io window after reset");
        rd_chk(6'd8,  32'h00000000, "R2 memory window after reset");
        rd_chk(6'd9,  32'h00010001, "R2 prefetch window after reset");
        rd_chk(6'd10, 32'h00000000, "R2 prefetch base upper after reset");
        rd_chk(6'd3,  32'h00810000, "R8 header type");
        // byte enables and plain registers
        wr(6'd6, 4'b1111, 32'h40050201, r, s);
        chk(r == 0, "R4 no remap for bus numbers", 32'(r), 32'h0);
        rd_chk(6'd6, 32'h40050201, "R11 bus numbers full write");
        wr(6'd6, 4'b0010, 32'hFFFFAAFF, r, s);
        rd_chk(6'd6, 32'h4005AA01, "R11 single byte write");
        // io window and read-only bits
        wr(6'd7, 4'b0011, 32'hFFFF5F3A, r, s);
        chk(r == 1, "R4 remap on io base/limit", 32'(r), 32'h1);
        rd_chk(6'd7, 32'h00A05131, "R10 io type nibbles kept");
        wr(6'd7, 4'b1100, 32'h12345678, r, s);
        chk(r == 0, "R4 no remap on secondary status bytes", 32'(r), 32'h0);
        rd_chk(6'd7, 32'h00A05131, "R10 secondary status ignored");
        wr(6'd8, 4'b1111, 32'h1238ABCF, r, s);
        chk(r == 1, "R4 remap on memory window", 32'(r), 32'h1);
        rd_chk(6'd8, 32'h1230ABC0, "R10 memory low nibbles ignored");
        wr(6'd12, 4'b0001, 32'h000000EE, r, s);
        chk(r == 1, "R4 remap on io upper (byte 0x30)", 32'(r), 32'h1);
        wr(6'd13, 4'b1111, 32'hFFFFFFFF, r, s);
        chk(r == 0, "R4 no remap at byte 0x34", 32'(r), 32'h0);
        rd_chk(6'd13, 32'h00000000, "R9 unmapped index reads zero");
        wr(6'd1, 4'b0100, 32'hFFFFFFFF, r, s);
        chk(r == 0, "R4 no remap on status byte", 32'(r), 32'h0);
        wr(6'd1, 4'b0001, 32'h00000007, r, s);
        chk(r == 1, "R4 remap on command byte", 32'(r), 32'h1);
        rd_chk(6'd1, 32'h00A00007, "R7 R10 command written, status fixed");
        wr(6'd3, 4'b0100, 32'h00000000, r, s);
        chk(r == 0, "R4 no remap on header", 32'(r), 32'h0);
        rd_chk(6'd3, 32'h00810000, "R10 R8 header write ignored");
        wr(6'd15, 4'b0011, 32'hFFFFFFFF, r, s);
        chk(r == 0, "R4 no remap on bytes 0x3C-0x3D", 32'(r), 32'h0);
        wr(6'd15, 4'b1000, 32'h00000000, r, s);
        chk(r == 1, "R4 remap on bridge control", 32'(r), 32'h1);
        // secondary bus reset
        wr(6'd15, 4'b0100, 32'h00400000, r, s);
        chk(s == 1, "R5 reset starts after rising write", 32'(s), 32'h1);
        hi = 1;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (sec_bus_reset) hi++;
            else break;
        end
        chk(hi == HOLD, "R5 reset pulse length", 32'(hi), 32'(HOLD));
        wr(6'd15, 4'b0100, 32'h00400000, r, s);
        chk(s == 0, "R6 no reset when bit already set", 32'(s), 32'h0);
        wr(6'd15, 4'b0100, 32'h00000000, r, s);
        chk(s == 0, "R6 no reset when clearing", 32'(s), 32'h0);
        wr(6'd15, 4'b1011, 32'hFFFFFFFF, r, s);
        chk(s == 0, "R6 no reset through disabled byte", 32'(s), 32'h0);
        rd_chk(6'd15, 32'hFF000000, "R11 control byte 2 untouched");
        wr(6'd15, 4'b0100, 32'h00400000, r, s);
        chk(s == 1, "R5 second rising write retriggers", 32'(s), 32'h1);
        repeat (4) @(negedge clk);
        rd_chk(6'd15, 32'hFF400000, "R9 control readback");
        // forwarding disable
        wr(6'd10, 4'b1111, 32'hDEADBEEF, r, s);
        wr(6'd11, 4'b1111, 32'h01234567, r, s);
        rd_chk(6'd11, 32'h01234567, "R9 prefetch limit upper readback");
        @(negedge clk); dis = 1;
        @(negedge clk); r = remap_pulse; dis = 0;
        chk(r == 1, "R3 remap on disable", 32'(r), 32'h1);
        rd_chk(6'd7,  32'h00A001F1, "R3 io window closed");
        rd_chk(6'd8,  32'h0000FFF0, "R3 memory window closed");
        rd_chk(6'd9,  32'h0001FFF1, "R3 prefetch window closed");
        rd_chk(6'd10, 32'h00000000, "R3 prefetch base upper cleared");
        rd_chk(6'd11, 32'h00000000, "R3 prefetch limit upper cleared");
        rd_chk(6'd12, 32'h000000EE, "R3 io upper untouched");
        rd_chk(6'd40, 32'h00000000, "R9 far unmapped index");
        // second reset
        @(negedge clk); rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        chk(sec_bus_reset === 1'b0, "R1 no secondary reset after reset", 32'(sec_bus_reset), 32'h0);
        rd_chk(6'd7,  32'h00A00101, "R2 io window after second reset");
        rd_chk(6'd15, 32'h00000000, "R1 control after second reset");
        rd_chk(6'd6,  32'h00000000, "R1 bus numbers after second reset");
        repeat (2) @(negedge clk);
        done = 1;
        summary();
        $finish;
    end
endmodule